// File: doc/BRIEF.md
# Cascadable Priority Encoder with Registered 16-Line Output

This block turns a bank of active-low request lines into the binary number of the highest-numbered line that is asserted. Each line is low when it is requesting. The block is built from identical 8-line encoder slices. Each slice has an active-low enable input and drives an active-low "nothing requested here" output that enables the next slice down. Each slice also drives an active-low "group active" flag. With the default parameters, two slices form a 16-line-to-4-line encoder. A small merge stage combines the slice outputs.

A plain OR-based encoder returns a mixed-up code when several lines are low at once. Here the highest-numbered line always wins. All code outputs are active low, so the block drives the bitwise inverse of the winning line's index. The merged result is captured in an output register with a synchronous, active-high reset. The chain output stays available, so a further stage of encoders can be cascaded below this one.

Top module: `prienc_cascade`

## Requirements
- R1: When enabled (`en_n` = 0), `code_n` equals the bitwise inverse of the 4-bit index of the highest-numbered `req_n` bit that is 0. Lines 15..8 outrank lines 7..0, and line 15 gives `code_n` = 4'h0.
- R2: Requests are active low. With `en_n` = 0 and every `req_n` bit at 1, `code_n` is 4'hF.
- R3: While `en_n` = 1, `code_n` = 4'hF, `grp_n` = 1 and `eo_n` = 1, whatever `req_n` holds.
- R4: `grp_n` is 0 exactly when `en_n` was 0 and at least one `req_n` bit was 0.
- R5: `eo_n` is 0 exactly when `en_n` was 0 and every `req_n` bit was 1, so that a following lower-priority encoder may be enabled.
- R6: When enabled, `code_n[3]` is 0 exactly when at least one of `req_n[15:8]` is 0.
- R7: When `req_n[15:8]` are all 1 and the block is enabled, the lower slice resolves lines 7..0 and `code_n` = {1'b1, inverse of the 3-bit index}.
- R8: Outputs change one clock after their inputs. A synchronous reset (`rst` = 1) forces `code_n` = 4'hF, `grp_n` = 1 and `eo_n` = 1.
- R9: `grp_n` and `eo_n` are never 0 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_n | input | 1 | Encoder enable, active low |
| req_n | input | 16 | Request lines, active low, line 15 highest |
| code_n | output | 4 | Registered code of winning line, active low |
| grp_n | output | 1 | Registered "some line requesting", active low |
| eo_n | output | 1 | Registered enable for a lower-priority encoder, active low |

## Verification
The assertions compare each registered output with the inputs held one cycle earlier. They therefore assume that `en_n` and `req_n` are steady across each rising edge, and they skip the first cycle after reset, because the register then holds its reset value rather than a result. The stimulus changes inputs only on falling edges and samples on the following falling edge. It walks all 65536 request patterns with the block enabled, then applies directed patterns with the block disabled and during reset.

// File: rtl/prienc_pkg.sv
package prienc_pkg;
  localparam int unsigned PRIENC_LINES  = 8;
  localparam int unsigned PRIENC_SLICES = 2;
endpackage

// File: rtl/prienc_slice.sv
module prienc_slice #(
  parameter int unsigned LINES = prienc_pkg::PRIENC_LINES,
  localparam int unsigned CW = $clog2(LINES)
) (
  input  logic [LINES-1:0] req_n,
  input  logic             en_n,
  output logic [CW-1:0]    code_n,
  output logic             gs_n,
  output logic             eo_n
);
  logic [CW-1:0] idx;
  logic          any;

  // ascending scan: the last hit is the highest-numbered active line
  always_comb begin
    idx = '0;
    for (int i = 0; i < int'(LINES); i++) begin
      if (!req_n[i]) idx = CW'(i);
    end
  end

  assign any    = ~&req_n;
  assign code_n = (!en_n && any) ? ~idx : '1;
  assign gs_n   = ~(!en_n && any);
  assign eo_n   = ~(!en_n && !any);
endmodule

// File: rtl/prienc_merge.sv
module prienc_merge #(
  parameter int unsigned SLICES = prienc_pkg::PRIENC_SLICES,
  parameter int unsigned CW = 3,
  localparam int unsigned SEL_W = $clog2(SLICES)
) (
  input  logic [SLICES-1:0][CW-1:0] slice_code_n,
  input  logic [SLICES-1:0]         slice_gs_n,
  output logic [SEL_W+CW-1:0]       code_n,
  output logic                      gs_n
);
  logic [SEL_W-1:0] sel;
  logic [CW-1:0]    low;

  always_comb begin
    sel = '0;
    for (int s = 0; s < int'(SLICES); s++) begin
      if (!slice_gs_n[s]) sel = SEL_W'(s);
    end
  end

  // idle slices drive all ones, so AND keeps the active slice's code
  always_comb begin
    low = '1;
    for (int s = 0; s < int'(SLICES); s++) low = low & slice_code_n[s];
  end

  assign gs_n   = &slice_gs_n;
  assign code_n = gs_n ? '1 : {~sel, low};
endmodule

// File: rtl/prienc_cascade.sv
module prienc_cascade #(
  parameter int unsigned LINES  = prienc_pkg::PRIENC_LINES,
  parameter int unsigned SLICES = prienc_pkg::PRIENC_SLICES,
  localparam int unsigned TOTAL = LINES * SLICES,
  localparam int unsigned OW = $clog2(TOTAL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_n,
  input  logic [TOTAL-1:0] req_n,
  output logic [OW-1:0]    code_n,
  output logic             grp_n,
  output logic             eo_n
);
  localparam int unsigned CW = $clog2(LINES);

  logic [SLICES:0]             chain_n;
  logic [SLICES-1:0][CW-1:0]   s_code_n;
  logic [SLICES-1:0]           s_gs_n;
  logic [OW-1:0]               m_code_n;
  logic                        m_gs_n;

  assign chain_n[SLICES] = en_n;

  // highest slice sits first in the enable chain
  for (genvar s = 0; s < int'(SLICES); s++) begin : g_slice
    prienc_slice #(.LINES(LINES)) u_slice (
      .req_n  (req_n[s*LINES +: LINES]),
      .en_n   (chain_n[s+1]),
      .code_n (s_code_n[s]),
      .gs_n   (s_gs_n[s]),
      .eo_n   (chain_n[s])
    );
  end

  prienc_merge #(.SLICES(SLICES), .CW(CW)) u_merge (
    .slice_code_n (s_code_n),
    .slice_gs_n   (s_gs_n),
    .code_n       (m_code_n),
    .gs_n         (m_gs_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      code_n <= '1;
      grp_n  <= 1'b1;
      eo_n   <= 1'b1;
    end else begin
      code_n <= m_code_n;
      grp_n  <= m_gs_n;
      eo_n   <= chain_n[0];
    end
  end
endmodule

// File: rtl/prienc_cascade_chk.sv
module prienc_cascade_chk #(
  parameter int unsigned TOTAL = 16,
  parameter int unsigned OW = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             en_n,
  input logic [TOTAL-1:0] req_n,
  input logic [OW-1:0]    code_n,
  input logic             grp_n,
  input logic             eo_n
);
  localparam int unsigned HALF = TOTAL / 2;

  a_r3_disabled_idle: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(en_n)) |-> (code_n == '1 && grp_n && eo_n));

  a_r4_group_flag: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (grp_n == ($past(en_n) || (&$past(req_n)))));

  a_r5_chain_out: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (eo_n == ($past(en_n) || !(&$past(req_n)))));

  a_r6_upper_msb: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(en_n)) |-> (code_n[OW-1] == (&$past(req_n[TOTAL-1:HALF]))));

  a_r8_reset_value: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (code_n == '1 && grp_n && eo_n));

  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(grp_n == 1'b0 && eo_n == 1'b0));
endmodule

bind prienc_cascade prienc_cascade_chk #(.TOTAL(TOTAL), .OW(OW)) u_chk (
  .clk(clk), .rst(rst), .en_n(en_n), .req_n(req_n),
  .code_n(code_n), .grp_n(grp_n), .eo_n(eo_n)
);

// File: tb/prienc_cascade_tb.sv
module prienc_cascade_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en_n = 1'b1;
  logic [15:0] req_n = '1;
  logic [3:0]  code_n;
  logic        grp_n;
  logic        eo_n;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  prienc_cascade u_dut (
    .clk(clk), .rst(rst), .en_n(en_n), .req_n(req_n),
    .code_n(code_n), .grp_n(grp_n), .eo_n(eo_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {en_n, req_n, code_n, grp_n, eo_n}
  localparam int NV = 14;
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 16'hFFFF, 4'hF, 1'b1, 1'b0},
    {1'b0, 16'hFFFE, 4'hF, 1'b0, 1'b1},
    {1'b0, 16'h7FFF, 4'h0, 1'b0, 1'b1},
    {1'b0, 16'h0000, 4'h0, 1'b0, 1'b1},
    {1'b0, 16'hFEFF, 4'h7, 1'b0, 1'b1},
    {1'b0, 16'hFF7F, 4'h8, 1'b0, 1'b1},
    {1'b0, 16'h7F7F, 4'h0, 1'b0, 1'b1},
    {1'b0, 16'hFFEA, 4'hB, 1'b0, 1'b1},
    {1'b0, 16'hEAFF, 4'h3, 1'b0, 1'b1},
    {1'b1, 16'h0000, 4'hF, 1'b1, 1'b1},
    {1'b1, 16'hFFFF, 4'hF, 1'b1, 1'b1},
    {1'b0, 16'hFDFF, 4'h6, 1'b0, 1'b1},
    {1'b0, 16'hBFFF, 4'h1, 1'b0, 1'b1},
    {1'b0, 16'hFFFD, 4'hE, 1'b0, 1'b1}
  };

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: req_n=%h en_n=%b got {code,grp,eo}=%h expected %h",
               tag, req_n, en_n, act, exp);
    end
  endtask

  function automatic logic [5:0] model(input logic en, input logic [15:0] r);
    logic [3:0] c;
    logic found;
    c = 4'hF;
    found = 1'b0;
    for (int i = 15; i >= 0; i--) begin
      if (!found && !r[i]) begin
        c = ~4'(i);
        found = 1'b1;
      end
    end
    if (en) return {4'hF, 1'b1, 1'b1};
    return {c, ~found, found};
  endfunction

  task automatic apply(input logic en, input logic [15:0] r);
    @(negedge clk);
    en_n  = en;
    req_n = r;
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000) begin
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset value
    check("R8", {code_n, grp_n, eo_n}, 6'b111111);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][22], VEC[v][21:6]);
      if (VEC[v][22]) check("R3", {code_n, grp_n, eo_n}, VEC[v][5:0]);
      else if (VEC[v][21:6] == 16'hFFFF) check("R2", {code_n, grp_n, eo_n}, VEC[v][5:0]);
      else check("R1", {code_n, grp_n, eo_n}, VEC[v][5:0]);
    end

    // exhaustive walk over all request patterns, enabled
    for (int p = 0; p < 65536; p++) begin
      apply(1'b0, 16'(p));
      if (16'(p) == 16'hFFFF) check("R5", {code_n, grp_n, eo_n}, model(1'b0, 16'(p)));
      else if (16'(p) >= 16'hFF00) check("R7", {code_n, grp_n, eo_n}, model(1'b0, 16'(p)));
      else check("R1", {code_n, grp_n, eo_n}, model(1'b0, 16'(p)));
      if (p % 4096 == 0) begin
        check("R4", {5'b0, grp_n}, {5'b0, &req_n});
        check("R6", {5'b0, code_n[3]}, {5'b0, &req_n[15:8]});
        check("R9", {5'b0, grp_n | eo_n}, 6'b000001);
      end
    end

    // R8 latency: output holds until the next rising edge
    apply(1'b0, 16'h7FFF);
    @(negedge clk);
    en_n  = 1'b0;
    req_n = 16'hFFFE;
    #1;
    check("R8", {code_n, grp_n, eo_n}, {4'h0, 1'b0, 1'b1});
    @(negedge clk);
    check("R8", {code_n, grp_n, eo_n}, {4'hF, 1'b0, 1'b1});

    // R3 disabled with mixed requests
    apply(1'b1, 16'h1234);
    check("R3", {code_n, grp_n, eo_n}, 6'b111111);

    // R8 synchronous reset with active requests
    @(negedge clk);
    en_n  = 1'b0;
    req_n = 16'h0000;
    rst   = 1'b1;
    @(negedge clk);
    check("R8", {code_n, grp_n, eo_n}, 6'b111111);
    rst = 1'b0;
    @(negedge clk);
    check("R1", {code_n, grp_n, eo_n}, {4'h0, 1'b0, 1'b1});

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule